// File: doc/BRIEF.md
# Front-End Stack Pointer Tracker

This unit sits on the decode side of a processor front end. It watches each decoded group for push, pop, call and return instructions. It keeps the stack pointer changes they cause in a running signed delta, using its own adder. Because of this, none of these instructions needs a separate stack-pointer update micro-op in the integer units. Each tracked memory micro-op leaves the unit tagged with the delta it should add to the architectural stack pointer to form its address.

When an instruction reads or writes the stack pointer explicitly, the architectural register must be made current first. The same is true when the next adjustment would push the delta outside its signed range. In both cases the unit asks for one synchronisation micro-op ahead of that instruction, carrying the delta to be folded in, and the delta then restarts from zero. Several instructions in one decode group are handled in lane order within a single cycle. A pipeline flush discards the delta, since recovery restores the architectural value.

Top module: `spt_tracker`

## Requirements
- R1: After reset, run_delta_o is 0 and every bit of uop_vld_o, sync_o, mem_ofs_o and sync_delta_o is 0.
- R2: Operation codes on grp_op_i are 0 none, 1 push, 2 pop, 3 call, 4 return, 5 explicit stack-pointer read, 6 explicit stack-pointer write. Push and call subtract the step from the delta, and pop and return add it. The step is 4, or 2 when the lane's grp_half_i bit is 1.
- R3: A push or call lane's mem_ofs_o is the delta after its adjustment. A pop or return lane's mem_ofs_o is the delta before its adjustment. Every other lane shows an offset of 0.
- R4: An explicit read or write lane raises its sync_o bit, and its sync_delta_o equals the delta entering that lane. The delta after that lane is 0, and its mem_ofs_o is 0.
- R5: If a push, call, pop or return would take the delta outside -128..127, the lane raises sync_o with the entering delta. The adjustment is then applied starting from 0. For example, a push of 4 leaves -4 with offset -4, and a pop of 4 leaves 4 with offset 0.
- R6: Lanes of one group are processed in order, lane 0 first. Each lane sees the delta left by the lanes below it, and run_delta_o shows the delta after the last lane.
- R7: A cycle with flush_i high sets run_delta_o to 0 and ignores that cycle's group. All uop_vld_o and sync_o bits are then 0.
- R8: A lane whose grp_vld_i bit is 0, or a valid lane with op 0, changes no delta, raises no sync_o and shows an offset of 0.
- R9: All outputs are registered. A group presented at one rising edge appears on the outputs after that edge, and uop_vld_o mirrors grp_vld_i.
- R10: When a sync_o bit is 0, the matching sync_delta_o field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush, clears the delta |
| grp_vld_i | input | LANES | Per-lane instruction valid |
| grp_op_i | input | 3*LANES | Per-lane stack operation code |
| grp_half_i | input | LANES | Per-lane 16-bit operand size |
| uop_vld_o | output | LANES | Registered lane valid |
| mem_ofs_o | output | DW*LANES | Per-lane stack-pointer offset for the memory micro-op |
| sync_o | output | LANES | Insert a synchronisation micro-op ahead of this lane |
| sync_delta_o | output | DW*LANES | Delta carried by the synchronisation micro-op |
| run_delta_o | output | DW | Running delta after the last processed group |

## Verification
Every result of this unit, including lane offsets, sync requests, sync deltas and the running delta, is due one cycle after the group is applied. The bench drives each group on a falling edge and waits for the next rising edge. It then reads the outputs one nanosecond later, so each check sees exactly the registered result of the group just applied. Long tests that walk the delta toward its limits check only the running delta after the final walking group. The outputs of the group that crosses a limit are checked in the cycle after that group.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SP_RD = 3'd5,
    OP_SP_WR = 3'd6
  } stk_op_e;
endpackage

// File: rtl/spt_lane.sv
module spt_lane
  import spt_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STEP_W = 4,
  parameter int STEP_H = 2
) (
  input  logic          vld_i,
  input  logic [2:0]    op_i,
  input  logic          half_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] ofs_o,
  output logic          sync_o,
  output logic [DW-1:0] sync_val_o,
  output logic [DW-1:0] d_o
);
  logic          is_sub, is_add, is_exp, ovf;
  logic [DW:0]   step, sum, neg_step;

  always_comb begin
    is_sub   = (op_i == OP_PUSH) || (op_i == OP_CALL);
    is_add   = (op_i == OP_POP)  || (op_i == OP_RET);
    is_exp   = (op_i == OP_SP_RD) || (op_i == OP_SP_WR);
    step     = half_i ? (DW+1)'(STEP_H) : (DW+1)'(STEP_W);
    neg_step = -step;
    sum      = is_sub ? ({d_i[DW-1], d_i} - step) : ({d_i[DW-1], d_i} + step);
    ovf      = sum[DW] != sum[DW-1];
    ofs_o      = '0;
    sync_o     = 1'b0;
    sync_val_o = '0;
    d_o        = d_i;
    if (vld_i) begin
      if (is_exp) begin
        sync_o     = 1'b1;
        sync_val_o = d_i;
        d_o        = '0;
      end else if (is_sub || is_add) begin
        if (ovf) begin
          // fold delta into architectural SP, restart from zero
          sync_o     = 1'b1;
          sync_val_o = d_i;
          d_o        = is_sub ? neg_step[DW-1:0] : step[DW-1:0];
        end else begin
          d_o = sum[DW-1:0];
        end
        ofs_o = is_sub ? d_o : (ovf ? '0 : d_i);
      end
    end
  end
endmodule

// File: rtl/spt_chain.sv
module spt_chain #(
  parameter int LANES  = 2,
  parameter int DW     = 8,
  parameter int STEP_W = 4,
  parameter int STEP_H = 2
) (
  input  logic [LANES-1:0]    vld_i,
  input  logic [3*LANES-1:0]  op_i,
  input  logic [LANES-1:0]    half_i,
  input  logic [DW-1:0]       d_i,
  output logic [DW*LANES-1:0] ofs_o,
  output logic [LANES-1:0]    sync_o,
  output logic [DW*LANES-1:0] sync_val_o,
  output logic [DW-1:0]       d_o
);
  logic [DW-1:0] d_chain [LANES+1];

  assign d_chain[0] = d_i;
  assign d_o        = d_chain[LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spt_lane #(.DW(DW), .STEP_W(STEP_W), .STEP_H(STEP_H)) u_lane (
      .vld_i      (vld_i[g]),
      .op_i       (op_i[3*g +: 3]),
      .half_i     (half_i[g]),
      .d_i        (d_chain[g]),
      .ofs_o      (ofs_o[DW*g +: DW]),
      .sync_o     (sync_o[g]),
      .sync_val_o (sync_val_o[DW*g +: DW]),
      .d_o        (d_chain[g+1])
    );
  end
endmodule

// File: rtl/spt_tracker.sv
module spt_tracker
  import spt_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DW     = 8,
  parameter int STEP_W = 4,
  parameter int STEP_H = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [LANES-1:0]    grp_vld_i,
  input  logic [3*LANES-1:0]  grp_op_i,
  input  logic [LANES-1:0]    grp_half_i,
  output logic [LANES-1:0]    uop_vld_o,
  output logic [DW*LANES-1:0] mem_ofs_o,
  output logic [LANES-1:0]    sync_o,
  output logic [DW*LANES-1:0] sync_delta_o,
  output logic [DW-1:0]       run_delta_o
);
  logic [DW*LANES-1:0] ofs_c, sval_c;
  logic [LANES-1:0]    sync_c;
  logic [DW-1:0]       d_next;

  spt_chain #(.LANES(LANES), .DW(DW), .STEP_W(STEP_W), .STEP_H(STEP_H)) u_chain (
    .vld_i      (grp_vld_i),
    .op_i       (grp_op_i),
    .half_i     (grp_half_i),
    .d_i        (run_delta_o),
    .ofs_o      (ofs_c),
    .sync_o     (sync_c),
    .sync_val_o (sval_c),
    .d_o        (d_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uop_vld_o    <= '0;
      mem_ofs_o    <= '0;
      sync_o       <= '0;
      sync_delta_o <= '0;
      run_delta_o  <= '0;
    end else if (flush_i) begin
      uop_vld_o    <= '0;
      mem_ofs_o    <= '0;
      sync_o       <= '0;
      sync_delta_o <= '0;
      run_delta_o  <= '0;
    end else begin
      uop_vld_o    <= grp_vld_i;
      mem_ofs_o    <= ofs_c;
      sync_o       <= sync_c;
      sync_delta_o <= sval_c;
      run_delta_o  <= d_next;
    end
  end

  // R7
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (run_delta_o == '0) && (sync_o == '0) && (uop_vld_o == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && grp_vld_i == '0) |=> $stable(run_delta_o));

  // R9
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> uop_vld_o == $past(grp_vld_i));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4
    exp_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flush_i && grp_vld_i[g] &&
       (grp_op_i[3*g +: 3] == OP_SP_RD || grp_op_i[3*g +: 3] == OP_SP_WR))
      |=> sync_o[g] && (mem_ofs_o[DW*g +: DW] == '0));
    // R10
    sync_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_o[g] |-> sync_delta_o[DW*g +: DW] == '0);
  end
endmodule

// File: tb/sim_spt_tracker.sv
module sim_spt_tracker;
  localparam int LANES = 2;
  localparam int DW    = 8;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                flush_i = 1'b0;
  logic [LANES-1:0]    grp_vld_i = '0;
  logic [3*LANES-1:0]  grp_op_i = '0;
  logic [LANES-1:0]    grp_half_i = '0;
  logic [LANES-1:0]    uop_vld_o;
  logic [DW*LANES-1:0] mem_ofs_o;
  logic [LANES-1:0]    sync_o;
  logic [DW*LANES-1:0] sync_delta_o;
  logic [DW-1:0]       run_delta_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  spt_tracker #(.LANES(LANES), .DW(DW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input int exp);
    logic [31:0] e;
    e = 32'(exp);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [DW-1:0] v);
    return {{(32-DW){v[DW-1]}}, v};
  endfunction

  // apply a group at negedge, sample 1ns after the next posedge
  task automatic grp(input logic v0, input logic [2:0] o0, input logic h0,
                     input logic v1, input logic [2:0] o1, input logic h1,
                     input logic fl);
    @(negedge clk_i);
    grp_vld_i  = {v1, v0};
    grp_op_i   = {o1, o0};
    grp_half_i = {h1, h0};
    flush_i    = fl;
    @(posedge clk_i);
    #1;
    grp_vld_i = '0;
    grp_op_i  = '0;
    flush_i   = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 run_delta", sx(run_delta_o), 0);
    chk("R1 uop_vld", {30'd0, uop_vld_o}, 0);
    chk("R1 sync", {30'd0, sync_o}, 0);
    chk("R1 ofs", {16'd0, mem_ofs_o}, 0);
    chk("R1 sync_delta", {16'd0, sync_delta_o}, 0);
  endtask

  task automatic t_push_pop;
    grp(1, 3'd1, 0, 1, 3'd2, 1, 0);
    chk("R2 R6 run_delta", sx(run_delta_o), -2);
    chk("R3 push ofs", sx(mem_ofs_o[7:0]), -4);
    chk("R3 pop ofs", sx(mem_ofs_o[15:8]), -4);
    chk("R9 uop_vld", {30'd0, uop_vld_o}, 3);
    chk("R2 no sync", {30'd0, sync_o}, 0);
  endtask

  task automatic t_call_ret;
    grp(1, 3'd3, 0, 1, 3'd4, 0, 0);
    chk("R3 call ofs", sx(mem_ofs_o[7:0]), -6);
    chk("R3 ret ofs", sx(mem_ofs_o[15:8]), -6);
    chk("R2 run_delta", sx(run_delta_o), -2);
  endtask

  task automatic t_sp_read;
    grp(1, 3'd5, 0, 1, 3'd1, 0, 0);
    chk("R4 sync lane0", {31'd0, sync_o[0]}, 1);
    chk("R4 sync_delta", sx(sync_delta_o[7:0]), -2);
    chk("R4 ofs lane0", sx(mem_ofs_o[7:0]), 0);
    chk("R6 push after sync ofs", sx(mem_ofs_o[15:8]), -4);
    chk("R10 sync_delta lane1", sx(sync_delta_o[15:8]), 0);
    chk("R4 run_delta", sx(run_delta_o), -4);
  endtask

  task automatic t_idle;
    grp(0, 3'd0, 0, 0, 3'd0, 0, 0);
    chk("R8 idle run_delta", sx(run_delta_o), -4);
    chk("R9 idle uop_vld", {30'd0, uop_vld_o}, 0);
  endtask

  task automatic t_push_ovf;
    for (int i = 0; i < 15; i++) grp(1, 3'd1, 0, 1, 3'd1, 0, 0);
    chk("R2 walk down", sx(run_delta_o), -124);
    grp(1, 3'd1, 0, 1, 3'd1, 0, 0);
    chk("R5 lane0 ofs at limit", sx(mem_ofs_o[7:0]), -128);
    chk("R5 sync", {30'd0, sync_o}, 2);
    chk("R5 sync_delta", sx(sync_delta_o[15:8]), -128);
    chk("R5 push ofs restart", sx(mem_ofs_o[15:8]), -4);
    chk("R5 run_delta", sx(run_delta_o), -4);
  endtask

  task automatic t_flush;
    grp(1, 3'd1, 0, 1, 3'd5, 0, 1);
    chk("R7 run_delta", sx(run_delta_o), 0);
    chk("R7 uop_vld", {30'd0, uop_vld_o}, 0);
    chk("R7 sync", {30'd0, sync_o}, 0);
  endtask

  task automatic t_pop_ovf;
    for (int i = 0; i < 15; i++) grp(1, 3'd2, 0, 1, 3'd4, 0, 0);
    chk("R2 walk up", sx(run_delta_o), 120);
    grp(1, 3'd2, 0, 1, 3'd2, 0, 0);
    chk("R3 pop ofs pre", sx(mem_ofs_o[7:0]), 120);
    chk("R5 pop sync", {30'd0, sync_o}, 2);
    chk("R5 pop sync_delta", sx(sync_delta_o[15:8]), 124);
    chk("R5 pop ofs restart", sx(mem_ofs_o[15:8]), 0);
    chk("R5 pop run_delta", sx(run_delta_o), 4);
  endtask

  task automatic t_sp_write;
    grp(1, 3'd2, 0, 1, 3'd6, 0, 0);
    chk("R3 pop ofs", sx(mem_ofs_o[7:0]), 4);
    chk("R4 write sync", {30'd0, sync_o}, 2);
    chk("R4 write sync_delta", sx(sync_delta_o[15:8]), 8);
    chk("R4 write run_delta", sx(run_delta_o), 0);
  endtask

  task automatic t_ignored;
    grp(1, 3'd1, 1, 0, 3'd0, 0, 0);
    grp(0, 3'd1, 0, 1, 3'd0, 0, 0);
    chk("R8 invalid lane run_delta", sx(run_delta_o), -2);
    chk("R8 uop_vld", {30'd0, uop_vld_o}, 2);
    chk("R8 none ofs", sx(mem_ofs_o[15:8]), 0);
    chk("R8 invalid ofs", sx(mem_ofs_o[7:0]), 0);
    chk("R8 no sync", {30'd0, sync_o}, 0);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_push_pop();
    t_call_ret();
    t_sp_read();
    t_idle();
    t_push_ovf();
    t_flush();
    t_pop_ovf();
    t_sp_write();
    t_ignored();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule